// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front End

This block sits between a simple host register bus and the byte streams of a serial port. The host reaches word-indexed registers: an identity word, a data port, the receive queue fill level, an interrupt mask, the address and length registers of a transmit DMA engine and of a receive DMA engine, and the queue depth. A data-port write sends its low byte out on a one-cycle transmit strobe. A data-port read pops the oldest byte of a circular receive queue. A write to the transmit length register hands a job to an external transmit DMA engine; that engine finishes at once, so the transmit address advances by the job length.

Incoming bytes take one of two paths. A small state machine has the states `RXM_FIFO` and `RXM_DMA`. In `RXM_FIFO`, bytes fill the queue and the advertised receive credit is the free queue space. In `RXM_DMA`, bytes go out on a write port at the receive DMA address, and the credit is the remaining receive length. The machine has four named transitions. ARM (`RXM_FIFO` to `RXM_DMA`) happens on a nonzero write to the receive length. CANCEL (`RXM_DMA` to `RXM_FIFO`) happens on a write to the receive address. RELOAD happens on a write to the receive length while in `RXM_DMA`; if the value written is zero it returns to `RXM_FIFO`. DRAIN_DONE (`RXM_DMA` to `RXM_FIFO`) happens when the byte that brings the length to zero is accepted.

A single level interrupt combines three maskable sources and is registered.

Top module: `sport_front`

## Requirements
- R1: After reset the interrupt, the transmit strobe, the queue fill, the mask and all DMA registers are zero, and the receive credit equals DEPTH.
- R2: The register index is bus_addr shifted right by two. The indices are: 0 identity (DEV_ID), 1 data, 2 fill, 3 mask, 4 transmit address, 5 transmit length, 6 receive address, 7 receive length, 8 DEPTH. Indices above 8 read as zero and ignore writes. The fill, identity and depth registers ignore writes. Index 5 reads as zero.
- R3: Bytes accepted in `RXM_FIFO` are returned by data-port reads in arrival order, in bits 7:0 with the upper bits zero. Each read pops one byte, and the fill register reports the number of bytes held.
- R4: A data-port read while the queue is empty returns 0xFFFFFFFF and changes no state.
- R5: A data-port write raises tx_valid for exactly the following cycle, with tx_data equal to bits 7:0 of the written word.
- R6: rx_credit equals the receive length when that length is nonzero, and DEPTH minus the fill otherwise. A byte offered while rx_credit is zero is dropped.
- R7: In `RXM_DMA` an offered byte appears in the same cycle on rxdma_valid/rxdma_data at rxdma_addr. The receive address then increments and the length decrements. DRAIN_DONE returns the machine to `RXM_FIFO` when the length reaches zero.
- R8: A write to the receive address loads it and clears the receive length (CANCEL). This write takes priority over a byte accepted in the same cycle.
- R9: A write to index 5 pulses txdma_go in the same cycle, with txdma_addr equal to the current transmit address and txdma_len equal to the written word. The transmit address then advances by that word.
- R10: irq is registered and equals, one cycle after its source state, the OR of: mask bit 0 with a nonempty queue, mask bit 1 alone, and mask bit 2 with a zero receive length.
- R11: A data-port read and an accepted byte in the same cycle both take effect. The fill is unchanged, and the new byte queues behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_credit | output | 32 | Bytes the block can take now |
| rxdma_valid | output | 1 | Byte routed to the receive DMA engine |
| rxdma_addr | output | 32 | Target address of that byte |
| rxdma_data | output | 8 | The routed byte |
| txdma_go | output | 1 | Transmit DMA job start |
| txdma_addr | output | 32 | Job start address |
| txdma_len | output | 32 | Job length |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can meet in one cycle: a data-port pop, and a byte entering the queue from the receive stream. The bench provokes this on purpose. It reads the data port while offering a byte, once with the queue full (where the push must be refused), once with the queue part-filled, and once with it empty (where the read returns all ones but the push lands). Random traffic then repeats the overlap many times. The bench model pops before it pushes, and it judges the later read order, the fill register and rx_credit against the result.

// File: rtl/sport_pkg.sv
package sport_pkg;

    typedef enum logic [3:0] {
        REG_ID     = 4'd0,
        REG_DATA   = 4'd1,
        REG_FILL   = 4'd2,
        REG_IRQEN  = 4'd3,
        REG_TXADDR = 4'd4,
        REG_TXLEN  = 4'd5,
        REG_RXADDR = 4'd6,
        REG_RXLEN  = 4'd7,
        REG_DEPTH  = 4'd8
    } reg_idx_e;

    typedef enum logic {
        RXM_FIFO = 1'b0,
        RXM_DMA  = 1'b1
    } rx_mode_e;

    localparam int IRQ_FIFO_BIT  = 0;
    localparam int IRQ_TXDMA_BIT = 1;
    localparam int IRQ_RXDMA_BIT = 2;
    localparam int IRQ_BITS      = 3;

endpackage

// File: rtl/sport_rxq.sv
module sport_rxq #(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic              pop,
    output logic [7:0]        head,
    output logic [FILL_W-1:0] fill
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_slot;

    // write slot = read position + fill, wrapped at DEPTH
    always_comb begin
        int unsigned sum;
        sum = int'(rd_ptr) + int'(fill);
        if (sum >= DEPTH) sum = sum - DEPTH;
        wr_slot = PTR_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_slot] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            unique case ({push, pop})
                2'b10:   fill <= fill + FILL_W'(1);
                2'b01:   fill <= fill - FILL_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/sport_rxdma.sv
module sport_rxdma
    import sport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_wr,
    input  logic        len_wr,
    input  logic [31:0] wdata,
    input  logic        byte_in,
    output logic [31:0] addr,
    output logic [31:0] len,
    output rx_mode_e    mode
);
    rx_mode_e    mode_n;
    logic [31:0] addr_n;
    logic [31:0] len_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= RXM_FIFO;
            addr <= '0;
            len  <= '0;
        end else begin
            mode <= mode_n;
            addr <= addr_n;
            len  <= len_n;
        end
    end

    always_comb begin
        mode_n = mode;
        addr_n = addr_wr ? wdata : (byte_in ? addr + 32'd1 : addr);
        len_n  = addr_wr ? 32'd0 : (len_wr ? wdata : (byte_in ? len - 32'd1 : len));
        unique case (mode)
            RXM_FIFO: begin
                if (!addr_wr && len_wr && wdata != 32'd0) mode_n = RXM_DMA;      // ARM
            end
            RXM_DMA: begin
                if (addr_wr)                              mode_n = RXM_FIFO;     // CANCEL
                else if (len_wr)                          mode_n = (wdata == 32'd0) ? RXM_FIFO : RXM_DMA; // RELOAD
                else if (byte_in && len == 32'd1)         mode_n = RXM_FIFO;     // DRAIN_DONE
            end
            default: mode_n = RXM_FIFO;
        endcase
    end

endmodule

// File: rtl/sport_irq.sv
module sport_irq
    import sport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_BITS-1:0] mask,
    input  logic                queue_nonempty,
    input  logic                rx_len_zero,
    output logic                irq
);
    logic level;

    always_comb begin
        level = (mask[IRQ_FIFO_BIT] && queue_nonempty)
              || mask[IRQ_TXDMA_BIT]
              || (mask[IRQ_RXDMA_BIT] && rx_len_zero);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= level;
    end

endmodule

// File: rtl/sport_front.sv
module sport_front
    import sport_pkg::*;
#(
    parameter int          DEPTH  = 16,
    parameter int          ADDR_W = 6,
    parameter logic [31:0] DEV_ID = 32'h5E71_A10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic [31:0]       rx_credit,
    output logic              rxdma_valid,
    output logic [31:0]       rxdma_addr,
    output logic [7:0]        rxdma_data,
    output logic              txdma_go,
    output logic [31:0]       txdma_addr,
    output logic [31:0]       txdma_len,
    output logic              irq
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int IDX_W  = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic [1:0]          unused_low;
    logic                wr_data, rd_data, wr_irqen, wr_txaddr, wr_txlen, wr_rxaddr, wr_rxlen;
    logic [FILL_W-1:0]   fill;
    logic [7:0]          head;
    logic [IRQ_BITS-1:0] irq_en;
    logic [31:0]         tx_addr;
    logic [31:0]         rx_addr;
    logic [31:0]         rx_len;
    rx_mode_e            rx_mode;
    logic                is_dma, rx_take, q_push, q_pop;

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_low = bus_addr[1:0];

    assign wr_data   = bus_sel &&  bus_wr && idx == IDX_W'(REG_DATA);
    assign rd_data   = bus_sel && !bus_wr && idx == IDX_W'(REG_DATA);
    assign wr_irqen  = bus_sel &&  bus_wr && idx == IDX_W'(REG_IRQEN);
    assign wr_txaddr = bus_sel &&  bus_wr && idx == IDX_W'(REG_TXADDR);
    assign wr_txlen  = bus_sel &&  bus_wr && idx == IDX_W'(REG_TXLEN);
    assign wr_rxaddr = bus_sel &&  bus_wr && idx == IDX_W'(REG_RXADDR);
    assign wr_rxlen  = bus_sel &&  bus_wr && idx == IDX_W'(REG_RXLEN);

    // receive routing and flow control
    assign is_dma      = (rx_mode == RXM_DMA);
    assign rx_credit   = is_dma ? rx_len : (32'(DEPTH) - 32'(fill));
    assign rx_take     = rx_valid && (rx_credit != 32'd0);
    assign q_push      = rx_take && !is_dma;
    assign q_pop       = rd_data && (fill != '0);
    assign rxdma_valid = rx_take && is_dma;
    assign rxdma_addr  = rx_addr;
    assign rxdma_data  = rx_data;

    assign txdma_go   = wr_txlen;
    assign txdma_addr = tx_addr;
    assign txdma_len  = bus_wdata;

    sport_rxq #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (rx_data),
        .pop       (q_pop),
        .head      (head),
        .fill      (fill)
    );

    sport_rxdma u_rxdma (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (wr_rxaddr),
        .len_wr  (wr_rxlen),
        .wdata   (bus_wdata),
        .byte_in (rxdma_valid),
        .addr    (rx_addr),
        .len     (rx_len),
        .mode    (rx_mode)
    );

    sport_irq u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .mask           (irq_en),
        .queue_nonempty (fill != '0),
        .rx_len_zero    (rx_len == 32'd0),
        .irq            (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= '0;
            tx_addr  <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            if (wr_irqen)      irq_en  <= bus_wdata[IRQ_BITS-1:0];
            if (wr_txaddr)     tx_addr <= bus_wdata;
            else if (wr_txlen) tx_addr <= tx_addr + bus_wdata;
            tx_valid <= wr_data;
            if (wr_data) tx_data <= bus_wdata[7:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_W'(REG_ID):     bus_rdata = DEV_ID;
            IDX_W'(REG_DATA):   bus_rdata = (fill != '0) ? {24'd0, head} : '1;
            IDX_W'(REG_FILL):   bus_rdata = 32'(fill);
            IDX_W'(REG_IRQEN):  bus_rdata = 32'(irq_en);
            IDX_W'(REG_TXADDR): bus_rdata = tx_addr;
            IDX_W'(REG_TXLEN):  bus_rdata = '0;
            IDX_W'(REG_RXADDR): bus_rdata = rx_addr;
            IDX_W'(REG_RXLEN):  bus_rdata = rx_len;
            IDX_W'(REG_DEPTH):  bus_rdata = 32'(DEPTH);
            default:            bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sport_front_chk.sv
module sport_front_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic [31:0]       rx_credit,
    input logic              rxdma_valid,
    input logic              irq,
    input logic [FILL_W-1:0] fill,
    input logic [31:0]       rx_len,
    input logic              rx_mode,
    input logic [2:0]        irq_en
);
    logic [ADDR_W-3:0] cidx;
    logic data_wr, data_rd, rxa_wr, rxl_wr, fifo_push;

    assign cidx      = bus_addr[ADDR_W-1:2];
    assign data_wr   = bus_sel &&  bus_wr && cidx == 1;
    assign data_rd   = bus_sel && !bus_wr && cidx == 1;
    assign rxa_wr    = bus_sel &&  bus_wr && cidx == 6;
    assign rxl_wr    = bus_sel &&  bus_wr && cidx == 7;
    assign fifo_push = rx_valid && !rx_mode && rx_credit != 32'd0;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fill) <= DEPTH); // R3

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fill == '0 && !fifo_push) |=> fill == '0); // R4

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(data_wr)); // R5

    AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode |-> rx_credit <= DEPTH); // R6

    AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode == (rx_len != 32'd0)); // R7

    AST_DMA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdma_valid && !rxa_wr && !rxl_wr) |=> rx_len == $past(rx_len) - 32'd1); // R7

    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        rxa_wr |=> rx_len == 32'd0); // R8

    AST_IRQ_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[1] |=> irq); // R10

endmodule

bind sport_front sport_front_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .tx_valid    (tx_valid),
    .rx_valid    (rx_valid),
    .rx_credit   (rx_credit),
    .rxdma_valid (rxdma_valid),
    .irq         (irq),
    .fill        (fill),
    .rx_len      (rx_len),
    .rx_mode     (rx_mode),
    .irq_en      (irq_en)
);

// File: tb/sport_front_test.sv
`timescale 1ns/1ps
module sport_front_test;
    localparam int          DEPTH  = 16;
    localparam int          ADDR_W = 6;
    localparam logic [31:0] DEV_ID = 32'h5E71_A10C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tx_valid;
    logic [7:0] tx_data;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [31:0] rx_credit;
    logic rxdma_valid;
    logic [31:0] rxdma_addr;
    logic [7:0] rxdma_data;
    logic txdma_go;
    logic [31:0] txdma_addr, txdma_len;
    logic irq;

    always #2 clk = ~clk;

    sport_front #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_credit(rx_credit), .rxdma_valid(rxdma_valid),
        .rxdma_addr(rxdma_addr), .rxdma_data(rxdma_data), .txdma_go(txdma_go),
        .txdma_addr(txdma_addr), .txdma_len(txdma_len), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0]  q[$];
    logic [2:0]  m_en = '0;
    logic [31:0] m_txa = '0, m_rxa = '0, m_rxc = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input int idx);
        case (idx)
            0: return DEV_ID;
            1: return (q.size() != 0) ? {24'd0, q[0]} : 32'hFFFF_FFFF;
            2: return 32'(q.size());
            3: return {29'd0, m_en};
            4: return m_txa;
            6: return m_rxa;
            7: return m_rxc;
            8: return 32'(DEPTH);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input int idx);
        if (idx == 1) return (q.size() != 0) ? "R3 data" : "R4 empty";
        if (idx == 2) return "R3 fill";
        return "R2 map";
    endfunction

    function automatic logic model_irq();
        return (m_en[0] && q.size() != 0) || m_en[1] || (m_en[2] && m_rxc == 0);
    endfunction

    task automatic step(input logic s, input logic w, input int idx,
                        input logic [31:0] wd, input logic rv, input logic [7:0] rd);
        logic [31:0] credit;
        logic dma, take, exp_irq, exp_tx;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = ADDR_W'(idx * 4); bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        #1;
        dma    = (m_rxc != 0);
        credit = dma ? m_rxc : 32'(DEPTH - q.size());
        take   = rv && credit != 0;
        check("R6 credit", rx_credit, credit);
        if (s && !w) check(read_tag(idx), bus_rdata, model_read(idx));
        check("R7 dma valid", {31'd0, rxdma_valid}, {31'd0, take && dma});
        if (take && dma) begin
            check("R7 dma addr", rxdma_addr, m_rxa);
            check("R7 dma data", {24'd0, rxdma_data}, {24'd0, rd});
        end
        check("R9 go", {31'd0, txdma_go}, {31'd0, s && w && idx == 5});
        if (s && w && idx == 5) begin
            check("R9 addr", txdma_addr, m_txa);
            check("R9 len", txdma_len, wd);
        end
        exp_irq = model_irq();
        exp_tx  = s && w && idx == 1;
        // model update: pop before push
        if (s && !w && idx == 1 && q.size() != 0) void'(q.pop_front());
        if (take && !dma) q.push_back(rd);
        if (take && dma) begin m_rxa = m_rxa + 1; m_rxc = m_rxc - 1; end
        if (s && w) begin
            case (idx)
                3: m_en = wd[2:0];
                4: m_txa = wd;
                5: m_txa = m_txa + wd;
                6: begin m_rxa = wd; m_rxc = 0; end
                7: m_rxc = wd;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check("R10 irq", {31'd0, irq}, {31'd0, exp_irq});
        check("R5 tx strobe", {31'd0, tx_valid}, {31'd0, exp_tx});
        if (exp_tx) check("R5 tx byte", {24'd0, tx_data}, {24'd0, wd[7:0]});
    endtask

    task automatic rd(input int idx);            step(1, 0, idx, 0, 0, 0);  endtask
    task automatic wr(input int idx, input logic [31:0] v); step(1, 1, idx, v, 0, 0); endtask
    task automatic rx(input logic [7:0] b);      step(0, 0, 0, 0, 1, b);  endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx", {31'd0, tx_valid}, 32'd0);
        check("R1 credit", rx_credit, 32'(DEPTH));
        rd(2); rd(3); rd(4); rd(6); rd(7);
        // R2 map, undefined and read-only
        rd(0); rd(8); rd(12);
        wr(12, 32'hDEAD_BEEF); rd(12);
        wr(2, 32'd7); rd(2);
        wr(0, 32'h1); rd(0); rd(5);
        // R4 empty reads
        rd(1); rd(1); rd(2);
        // R3, R10 fifo interrupt
        wr(3, 32'd1);
        rx(8'h11); rx(8'h22); rx(8'h33);
        rd(2); rd(1); rd(1); rd(1); rd(1);
        // R6 fill to full then drop
        for (int i = 0; i < DEPTH + 4; i++) rx(8'(8'h40 + i));
        rd(2);
        // R11 pop with byte offered while full (refused), then part-filled
        step(1, 0, 1, 0, 1, 8'hE0);
        step(1, 0, 1, 0, 1, 8'hE1);
        step(1, 0, 1, 0, 1, 8'hE2);
        rd(2);
        for (int i = 0; i < DEPTH + 1; i++) rd(1);
        // R11 empty queue: read gives ones, push lands
        step(1, 0, 1, 0, 1, 8'hE7);
        rd(1);
        // R7 DMA path and DRAIN_DONE, R10 rx-dma irq
        wr(3, 32'd4);
        wr(6, 32'h0000_1000); wr(7, 32'd3);
        rx(8'hA1); rx(8'hA2); rx(8'hA3); rx(8'hA4);
        rd(6); rd(7); rd(1);
        // R8 cancel, also with a byte in the same cycle
        wr(7, 32'd5); rx(8'hB1);
        step(1, 1, 6, 32'h0000_2000, 1, 8'hB2);
        rd(6); rd(7); rx(8'hB3); rd(1);
        // R5 transmit byte, R9 transmit dma
        wr(1, 32'h0000_01A5);
        wr(4, 32'h0000_0200); wr(5, 32'h10); rd(5); rd(4);
        wr(3, 32'd2); rd(3);
        wr(3, 32'd0);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int idx;
            logic [31:0] v;
            idx = int'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) idx = 1;
            v = $urandom();
            if (idx == 7) v = 32'($urandom_range(0, 6));
            if (idx == 3) v = 32'($urandom_range(0, 7));
            if (idx == 6 && $urandom_range(0, 3) != 0) idx = 2;
            step(1'($urandom_range(0, 9) < 7), 1'($urandom_range(0, 1)), idx, v,
                 1'($urandom_range(0, 1)), 8'($urandom()));
        end
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule